// File: doc/BRIEF.md
# Toggle-Cancel Timed Enable Generator

The block drives an enable output that stays high for a fixed number of clock cycles after a trigger. A free-running clock sets the time base, and a binary counter times each window. A trigger that arrives while the output is low opens a new window. A trigger that arrives while a window is open closes it at once. The trigger therefore works as a start/cancel toggle: it never restarts a window and is never ignored.

The trigger input is expected to come from a switch that has already been debounced. It is brought into the clock domain by a two-flop synchronizer, and its rising edge is turned into a single-cycle event. A build-time parameter picks how the end of a window is detected. One option is the all-ones carry of the full `CNT_W`-bit counter, which gives a window of 2^CNT_W cycles. The other is the increment that carries into the counter's top bit, which gives 2^(CNT_W-1) cycles. A one-cycle done pulse marks each window that runs to its natural end.

A third parameter, `HAS_RST`, builds the state flops without reset for systems that do not care about their start state. The reset input then has no effect.

Top module: `pulse_window_gen`

## Requirements
- R1: While rst_ni is low, en_o and done_o are 0 and the window counter is cleared. This holds regardless of the clock.
- R2: A rising edge on trig_i produces exactly one trigger event, however long trig_i then stays high. The event takes effect at the third rising clock edge that samples trig_i high, counting the first such edge as one.
- R3: With END_SEL = END_CARRY, a trigger event while en_o is 0 sets en_o to 1. en_o then stays high for exactly 2^CNT_W clock cycles if no further event arrives.
- R4: With END_SEL = END_MSB, the same window lasts exactly 2^(CNT_W-1) clock cycles.
- R5: A trigger event while en_o is 1 clears en_o at that same edge, before the window has run out.
- R6: When a window runs out, done_o is 1 for exactly one cycle. That cycle is the first one in which en_o is 0 again.
- R7: A window closed by a trigger event produces no done_o pulse.
- R8: If a trigger event falls on the last cycle of a window, en_o goes to 0, done_o stays 0, and no new window opens.
- R9: Every window, including one opened right after a cancel, starts counting from zero and lasts its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that sets the time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger from a debounced switch, asynchronous to clk_i |
| en_o | output | 1 | Enable window output |
| done_o | output | 1 | One-cycle pulse when a window ends by running out |

## Verification
The hardest case to reach is a trigger event that falls on exactly the last counted cycle of a window. To produce it, the trigger edge has to be placed three edges ahead of the terminal count, so the synchronizer delay must be budgeted precisely. A directed sequence takes the edge at which en_o rises and counts forward to launch the trigger on the one cycle that makes the two coincide. Cancels at other points in the window are reached with random hold lengths. A cycle-level model of both end-detect variants checks every cycle.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic {
    END_CARRY = 1'b0,
    END_MSB   = 1'b1
  } end_sel_e;
endpackage

// File: rtl/pwg_dff.sv
module pwg_dff #(
  parameter int unsigned    W       = 1,
  parameter bit             HAS_RST = 1'b1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= RST_VAL;
        else         q_o <= d_i;
      end
    end else begin : g_nrst
      always_ff @(posedge clk_i) q_o <= d_i;
    end
  endgenerate
endmodule

// File: rtl/pwg_trig_sync.sv
module pwg_trig_sync #(
  parameter bit HAS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic evt_o
);
  localparam int unsigned SH_W = 3;

  logic [SH_W-1:0] sh_q, sh_d;

  // [0],[1] synchronize; [2] holds previous synced level for edge detect
  assign sh_d = {sh_q[SH_W-2:0], trig_i};

  pwg_dff #(.W(SH_W), .HAS_RST(HAS_RST)) u_sh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sh_d),
    .q_o   (sh_q)
  );

  assign evt_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/pwg_win_cnt.sv
module pwg_win_cnt
  import pwg_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter end_sel_e    END_SEL = END_CARRY,
  parameter bit          HAS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  output logic term_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign cnt_d   = run_i ? cnt_inc : '0;

  pwg_dff #(.W(CNT_W), .HAS_RST(HAS_RST)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_d),
    .q_o   (cnt_q)
  );

  generate
    if (END_SEL == END_CARRY) begin : g_carry
      assign term_o = en_i & (&cnt_q);
    end else begin : g_msb
      // last cycle is the one whose increment would set the top bit
      assign term_o = en_i & cnt_inc[CNT_W-1] & ~cnt_q[CNT_W-1];
    end
  endgenerate
endmodule

// File: rtl/pwg_ctrl.sv
module pwg_ctrl #(
  parameter bit HAS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic term_i,
  output logic run_o,
  output logic en_o,
  output logic done_o
);
  logic [1:0] st_q, st_d;
  logic       en_q, en_d, done_d;

  assign en_q = st_q[0];

  always_comb begin
    en_d   = en_q;
    done_d = 1'b0;
    if (evt_i) en_d = ~en_q;
    if (term_i) begin
      en_d   = 1'b0;
      done_d = ~evt_i;  // cancel wins over expiry
    end
  end

  assign st_d  = {done_d, en_d};
  assign run_o = en_q & en_d;

  pwg_dff #(.W(2), .HAS_RST(HAS_RST)) u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (st_d),
    .q_o   (st_q)
  );

  assign en_o   = st_q[0];
  assign done_o = st_q[1];
endmodule

// File: rtl/pulse_window_gen.sv
module pulse_window_gen
  import pwg_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter end_sel_e    END_SEL = END_CARRY,
  parameter bit          HAS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic en_o,
  output logic done_o
);
  logic trig_evt, term_hit, run;

  pwg_trig_sync #(.HAS_RST(HAS_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .evt_o (trig_evt)
  );

  pwg_win_cnt #(.CNT_W(CNT_W), .END_SEL(END_SEL), .HAS_RST(HAS_RST)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_o),
    .run_i (run),
    .term_o(term_hit)
  );

  pwg_ctrl #(.HAS_RST(HAS_RST)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (trig_evt),
    .term_i(term_hit),
    .run_o (run),
    .en_o  (en_o),
    .done_o(done_o)
  );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker
  import pwg_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter end_sel_e    END_SEL = END_CARRY
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_o,
  input logic done_o,
  input logic trig_evt,
  input logic term_hit
);
  localparam int unsigned WIN = (END_SEL == END_CARRY) ? (1 << CNT_W) : (1 << (CNT_W - 1));

  int unsigned win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_cnt <= 0;
    else if (en_o) win_cnt <= win_cnt + 1;
    else           win_cnt <= 0;
  end

  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt |=> !trig_evt);  // R2

  AST_START_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && trig_evt) |=> en_o);  // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (win_cnt < WIN));  // R3

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(win_cnt) == WIN - 1));  // R4

  AST_CANCEL_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && trig_evt) |=> (!en_o && !done_o));  // R5

  AST_EXPIRE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_hit && !trig_evt) |=> (!en_o && done_o));  // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6

  AST_COINCIDE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_hit && trig_evt) |=> (!en_o && !done_o));  // R8
endmodule

bind pulse_window_gen pwg_checker #(.CNT_W(CNT_W), .END_SEL(END_SEL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_o    (en_o),
  .done_o  (done_o),
  .trig_evt(trig_evt),
  .term_hit(term_hit)
);

// File: tb/tb_pulse_window_gen.sv
module tb_pulse_window_gen;
  import pwg_pkg::*;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CW         = 4;
  localparam int          W_C        = 16;
  localparam int          W_M        = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0;
  logic en_c, done_c, en_m, done_m;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit cyc_chk = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pulse_window_gen #(.CNT_W(CW), .END_SEL(END_CARRY)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .en_o(en_c), .done_o(done_c));

  pulse_window_gen #(.CNT_W(CW), .END_SEL(END_MSB)) dut_msb (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .en_o(en_m), .done_o(done_m));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // reference model: event at edge m when trig sampled high at m-2 and low at m-3
  bit h1, h2, h3;
  bit m_en[2];
  bit m_done[2];
  int m_len[2];

  function automatic int win_of(input int i);
    return (i == 0) ? W_C : W_M;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1 = 0; h2 = 0; h3 = 0;
      for (int i = 0; i < 2; i++) begin
        m_en[i] = 0; m_done[i] = 0; m_len[i] = 0;
      end
    end else begin
      bit ev;
      ev = h2 && !h3;
      for (int i = 0; i < 2; i++) begin
        bit tc;
        tc = m_en[i] && (m_len[i] == win_of(i) - 1);
        m_done[i] = 0;
        if (ev && m_en[i]) begin
          m_en[i] = 0; m_len[i] = 0;
        end else if (tc) begin
          m_en[i] = 0; m_len[i] = 0; m_done[i] = 1;
        end else if (ev) begin
          m_en[i] = 1; m_len[i] = 0;
        end else if (m_en[i]) begin
          m_len[i]++;
        end
      end
      h3 = h2; h2 = h1; h1 = trig_i;
    end
  end

  always @(negedge clk_i) begin
    if (cyc_chk && rst_ni) begin
      check("R3 carry en_o vs model", en_c, m_en[0]);
      check("R4 msb en_o vs model", en_m, m_en[1]);
      check("R6 carry done_o vs model", done_c, m_done[0]);
      check("R6 msb done_o vs model", done_m, m_done[1]);
    end
  end

  task automatic measure(input int lc0, output int lc, output int lm, output int dc, output int dm);
    lc = lc0; lm = lc0; dc = 0; dm = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (en_c) lc++;
      if (en_m) lm++;
      if (done_c) begin dc++; check("R6 done_o with en_o low", en_c, 0); end
      if (done_m) begin dm++; check("R6 msb done_o with en_o low", en_m, 0); end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int lc, lm, dc, dm, cnt;
    void'($urandom(32'd20231));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 en_o in reset", en_c, 0);
    check("R1 done_o in reset", done_c, 0);
    check("R1 msb en_o in reset", en_m, 0);
    rst_ni = 1'b1;
    cyc_chk = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2 latency and held level, R3/R4 window lengths, R6 done
    trig_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R2 en_o before third edge", en_c, 0);
    @(negedge clk_i);
    check("R2 en_o at third edge", en_c, 1);
    measure(1, lc, lm, dc, dm);
    check("R3 carry window length", lc, W_C);
    check("R4 msb window length", lm, W_M);
    check("R6 carry done pulses", dc, 1);
    check("R6 msb done pulses", dm, 1);
    check("R2 held trig gives one event", en_c, 0);
    trig_i = 1'b0;
    repeat (6) @(negedge clk_i);

    // R5 cancel, R7 no done on cancel
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R5 window opened", en_c, 1);
    repeat (4) @(negedge clk_i);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    @(negedge clk_i);
    check("R5 still on before cancel edge", en_c, 1);
    @(negedge clk_i);
    check("R5 cancelled", en_c, 0);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (done_c) cnt++;
    end
    check("R7 no done after cancel", cnt, 0);

    // R9 full window after cancel
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9 reopened", en_c, 1);
    measure(1, lc, lm, dc, dm);
    check("R9 full window after cancel", lc, W_C);
    repeat (4) @(negedge clk_i);

    // R8 trigger event on the terminal cycle
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R8 window opened", en_c, 1);
    repeat (13) @(negedge clk_i);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    @(negedge clk_i);
    check("R8 on during last cycle", en_c, 1);
    @(negedge clk_i);
    check("R8 en_o off on coincidence", en_c, 0);
    check("R8 no done on coincidence", done_c, 0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (en_c || done_c) cnt++;
    end
    check("R8 no new window", cnt, 0);

    // random holds, checked cycle by cycle against the model
    for (int k = 0; k < 400; k++) begin
      trig_i = ~trig_i;
      repeat ($urandom_range(1, 24)) @(negedge clk_i);
    end
    trig_i = 1'b0;
    repeat (40) @(negedge clk_i);

    // R1 asynchronous reset mid-window
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    cyc_chk = 1'b0;
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    check("R1 async reset clears en_o", en_c, 0);
    check("R1 async reset clears msb en_o", en_m, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc_chk = 1'b1;
    trig_i = 1'b1;
    repeat (3) @(negedge clk_i);
    measure(1, lc, lm, dc, dm);
    check("R1 counter cleared by reset", lc, W_C);
    trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule